// File: doc/BRIEF.md
# DMA Request Edge-Detect Sequencer

This block sits between an active-low DMA request pin and a DMA channel engine. It samples the pin on the controller clock through a short synchronizer chain. A three-state sequencer then turns each low period of the pin into exactly one transfer-start pulse. After it issues a request, the sequencer waits for the engine to report that the transfer can go ahead. It then refuses further activation until the pin has been seen high again. As a result, a pin held low across several transfers cannot start more than one of them.

Enabling the channel puts the sequencer into its armed state. A pin that is already low at that moment therefore counts as a valid first activation, with no falling edge needed. Turning the channel off sends the sequencer to idle and withdraws both outputs at once.

The block also drives an active-low end-of-block strobe. The strobe is low only while the engine runs a bus cycle of the final transfer. It stays high during any foreign bus cycle that falls between that transfer's read and write. It may stay low through a refresh cycle that directly follows the final transfer.

Top module: `dreq_edge_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets synchronously. During reset `start_req` is 0 and `tend_n` is 1, whatever the other inputs are.
- R2: The pin is seen only through a two-stage synchronizer clocked on the rising edge. A low pulse that starts and ends between two rising edges produces no request. A low level present at one rising edge produces one request.
- R3: In the armed state, a pin that drops low before rising edge E1 raises `start_req` after edge E3, and `start_req` is high for exactly one cycle.
- R4: After a request, the sequencer holds until `xfer_grant` is 1 at a rising edge. Until then, pin activity produces no request.
- R5: After the grant, no further request is issued while the synchronized pin stays low, however many grants arrive.
- R6: Once the grant has been taken and the pin has been seen high, the next low level produces one new request.
- R7: When `chan_en` is 0, `start_req` is 0 and `tend_n` is 1 in the same cycle, and the sequencer goes idle. When `chan_en` is set before edge E1 with the pin already synchronized low, `start_req` is high after edge E2.
- R8: With `chan_en` at 1, `tend_n` is 0 in any cycle where `dma_cyc` is 1 and `last_xfer` is 1. It is 1 in any cycle where `dma_cyc` is 1 and `last_xfer` is 0.
- R9: `tend_n` is 1 in any cycle where `dma_cyc` is 0 and `rfsh_cyc` is 0. This covers a foreign bus cycle between the read and write of the final transfer, even with `last_xfer` at 1.
- R10: In a refresh cycle (`rfsh_cyc` = 1, `dma_cyc` = 0), `tend_n` may be 0 only when that refresh run directly follows a final-transfer DMA cycle. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all sampling and state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; low forces the sequencer idle |
| req_pin_n | input | 1 | External DMA request pin, active low, asynchronous |
| xfer_grant | input | 1 | Engine signals that the requested data transfer can proceed |
| dma_cyc | input | 1 | The current bus cycle is a DMA read or write of this channel |
| last_xfer | input | 1 | The current transfer is the final one of the block |
| rfsh_cyc | input | 1 | The current bus cycle is a refresh cycle |
| start_req | output | 1 | One-cycle transfer-start request to the engine |
| tend_n | output | 1 | End-of-block strobe, active low |

## Verification
A sequencer stuck in the wait-for-grant state shows up as missing requests when the pin toggles again. The bench sees this within the few cycles of the synchronizer latency. A sequencer that skips the blocked state shows up as extra `start_req` pulses while the pin is held low across grants. The bench counts those pulses over windows of five to ten cycles. A latency error of one register moves the request pulse off its expected edge, so it fails the exact-cycle checks at once. A faulty strobe decode shows up in the same cycle on `tend_n`, because the strobe is combinational from the bus-cycle inputs.

// File: rtl/dreq_seq_pkg.sv
`timescale 1ns/1ps
// Package dreq_seq_pkg
// Shared state encoding for the request sequencer.
package dreq_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,   // channel off
        SQ_ARMED   = 2'd1,   // waiting for a low request level
        SQ_PENDING = 2'd2,   // request issued, waiting for the engine
        SQ_BLOCKED = 2'd3    // transfer taken, waiting for a high level
    } seq_state_t;
endpackage

// File: rtl/dreq_sync.sv
`timescale 1ns/1ps
// Module dreq_sync
// Brings the asynchronous active-low request pin into the clock domain
// through a chain of STAGES flops. Assumes STAGES >= 2. Resets to the
// inactive (high) level so that reset never looks like a request.
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_q;

    // Shift the pin level along the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[LAST-1:0], pin_n};
    end

    assign level_n = pipe_q[LAST];
endmodule

// File: rtl/dreq_seq.sv
`timescale 1ns/1ps
// Module dreq_seq
// Three-state activation sequencer. It issues one start pulse per low
// period of the synchronized request level. It holds until the engine
// grants, then waits for a high level before it rearms. Assumes level_n is
// already synchronous to clk.
module dreq_seq
    import dreq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic level_n,
    input  logic grant,
    output logic start_req
);
    seq_state_t state_q, state_d;
    logic       pulse_q;

    // Next-state selection; a disabled channel always returns to idle.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:    state_d = SQ_ARMED;
                SQ_ARMED:   if (!level_n) state_d = SQ_PENDING;
                SQ_PENDING: if (grant)    state_d = SQ_BLOCKED;
                SQ_BLOCKED: if (level_n)  state_d = SQ_ARMED;
                default:    state_d = SQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Start pulse: set on the cycle the sequencer enters the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= enable && (state_q == SQ_ARMED) && !level_n;
    end

    assign start_req = pulse_q && enable;

    // R3: the start pulse lasts a single cycle.
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R3: a pulse is only present alongside the pending state.
    a_r3_pulse_in_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && enable) |-> (state_q == SQ_PENDING));

    // R4: without a grant the pending state is held.
    a_r4_hold_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == SQ_PENDING && !grant) |=> (state_q == SQ_PENDING));

    // R5: while the level stays low, the blocked state is held.
    a_r5_blocked_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == SQ_BLOCKED && !level_n) |=> (state_q == SQ_BLOCKED));

    // R7: a disabled channel goes idle with no pulse.
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == SQ_IDLE && !pulse_q));
endmodule

// File: rtl/dreq_tend.sv
`timescale 1ns/1ps
// Module dreq_tend
// Drives the active-low end-of-block strobe. It is low during DMA cycles
// of the final transfer. When HOLD_THRU_REFRESH is set, it also stays low
// through a refresh run that follows such a cycle directly. Assumes the
// bus-cycle qualifiers are registered and stable within each cycle.
module dreq_tend #(
    parameter bit HOLD_THRU_REFRESH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dma_cyc,
    input  logic last_xfer,
    input  logic rfsh_cyc,
    output logic tend_n
);
    logic final_cyc;
    logic tail_q;
    logic tail_low;

    assign final_cyc = dma_cyc && last_xfer;

    generate
        if (HOLD_THRU_REFRESH) begin : g_hold
            // Remember a final-transfer cycle for as long as a refresh run follows it.
            always_ff @(posedge clk) begin
                if (!rst_n) tail_q <= 1'b0;
                else        tail_q <= enable && (final_cyc || (rfsh_cyc && !dma_cyc && tail_q));
            end
            assign tail_low = rfsh_cyc && !dma_cyc && tail_q;
        end else begin : g_plain
            // No extension: the strobe follows final-transfer cycles only.
            always_ff @(posedge clk) begin
                tail_q <= 1'b0;
            end
            assign tail_low = 1'b0;
        end
    endgenerate

    assign tend_n = !(rst_n && enable && (final_cyc || tail_low));

    // R9: with no DMA and no refresh cycle the strobe stays high.
    a_r9_idle_bus_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_cyc && !rfsh_cyc) |-> tend_n);

    // R10: a refresh with no preceding final cycle keeps the strobe high.
    a_r10_refresh_needs_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_cyc && !dma_cyc && !tail_q) |-> tend_n);

    // R8: a non-final DMA cycle never drives the strobe low.
    a_r8_nonfinal_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cyc && !last_xfer) |-> tend_n);
endmodule

// File: rtl/dreq_edge_seq.sv
`timescale 1ns/1ps
// Module dreq_edge_seq
// Top level: synchronizes the DMA request pin, sequences it into single
// transfer-start pulses, and produces the end-of-block strobe. Assumes one
// clock domain for everything except req_pin_n.
module dreq_edge_seq #(
    parameter int SYNC_STAGES       = 2,
    parameter bit HOLD_THRU_REFRESH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic req_pin_n,
    input  logic xfer_grant,
    input  logic dma_cyc,
    input  logic last_xfer,
    input  logic rfsh_cyc,
    output logic start_req,
    output logic tend_n
);
    logic level_n;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (req_pin_n),
        .level_n (level_n)
    );

    dreq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (chan_en),
        .level_n   (level_n),
        .grant     (xfer_grant),
        .start_req (start_req)
    );

    dreq_tend #(.HOLD_THRU_REFRESH(HOLD_THRU_REFRESH)) u_tend (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (chan_en),
        .dma_cyc   (dma_cyc),
        .last_xfer (last_xfer),
        .rfsh_cyc  (rfsh_cyc),
        .tend_n    (tend_n)
    );

    // R7: a disabled channel shows both outputs inactive in the same cycle.
    a_r7_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!start_req && tend_n));
endmodule

// File: tb/dreq_edge_seq_test.sv
`timescale 1ns/1ps
// Bench for dreq_edge_seq: directed sweeps with expected values from the requirements.
module dreq_edge_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0;
    logic req_pin_n = 1'b1;
    logic xfer_grant = 1'b0;
    logic dma_cyc = 1'b0;
    logic last_xfer = 1'b0;
    logic rfsh_cyc = 1'b0;
    logic start_req;
    logic tend_n;

    int vectors = 0;
    int miscompares = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dreq_edge_seq uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .req_pin_n(req_pin_n),
        .xfer_grant(xfer_grant), .dma_cyc(dma_cyc), .last_xfer(last_xfer),
        .rfsh_cyc(rfsh_cyc), .start_req(start_req), .tend_n(tend_n)
    );

    // Count request pulses mid-cycle.
    always @(negedge clk) if (rst_n && start_req === 1'b1) pulses++;

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chkn(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs inactive even with active inputs
        chan_en = 1'b1; dma_cyc = 1'b1; last_xfer = 1'b1; req_pin_n = 1'b0;
        adv(3);
        chk("R1 start_req in reset", start_req, 1'b0);
        chk("R1 tend_n in reset", tend_n, 1'b1);
        chan_en = 1'b0; dma_cyc = 1'b0; last_xfer = 1'b0;
        rst_n = 1'b1;
        adv(4);
        chkn("R7 no request while disabled", pulses, 0);

        // R7: enable with the pin already low
        chan_en = 1'b1;
        adv(1);
        chk("R7 no request after first edge", start_req, 1'b0);
        adv(1);
        chk("R7 request after second edge", start_req, 1'b1);
        adv(1);
        chk("R3 pulse is one cycle", start_req, 1'b0);

        // R5: grants while the pin stays low issue nothing
        xfer_grant = 1'b1; adv(1); xfer_grant = 1'b0;
        pulses = 0;
        adv(10);
        xfer_grant = 1'b1; adv(3); xfer_grant = 1'b0;
        adv(5);
        chkn("R5 held low across grants", pulses, 0);

        // R3: exact latency from the armed state
        req_pin_n = 1'b1; adv(4);
        pulses = 0;
        req_pin_n = 1'b0;
        adv(2);
        chk("R3 no request at edge two", start_req, 1'b0);
        adv(1);
        chk("R3 request at edge three", start_req, 1'b1);
        adv(1);
        chk("R3 request falls after one cycle", start_req, 1'b0);

        // R4: pin toggles without a grant are ignored
        pulses = 0;
        req_pin_n = 1'b1; adv(4);
        req_pin_n = 1'b0; adv(4);
        chkn("R4 no request before grant", pulses, 0);
        xfer_grant = 1'b1; adv(1); xfer_grant = 1'b0;
        adv(5);
        chkn("R5 no request while still low", pulses, 0);
        // R6: high then low rearms
        req_pin_n = 1'b1; adv(4);
        req_pin_n = 1'b0; adv(5);
        chkn("R6 one request after rearm", pulses, 1);

        // back to armed with the pin high
        xfer_grant = 1'b1; adv(1); xfer_grant = 1'b0;
        req_pin_n = 1'b1; adv(4);

        // R2: glitch between edges is never sampled
        pulses = 0;
        req_pin_n = 1'b0; #1; req_pin_n = 1'b1;
        adv(6);
        chkn("R2 sub-sample glitch ignored", pulses, 0);
        req_pin_n = 1'b0; adv(1); req_pin_n = 1'b1;
        adv(6);
        chkn("R2 one-cycle low gives one request", pulses, 1);
        xfer_grant = 1'b1; adv(1); xfer_grant = 1'b0;
        adv(4);

        // R7: disable suppresses a request due at the next edge
        pulses = 0;
        req_pin_n = 1'b0; adv(2);
        chan_en = 1'b0;
        #0.5;
        chk("R7 start_req low when disabled", start_req, 1'b0);
        adv(4);
        chkn("R7 no request while disabled", pulses, 0);
        chan_en = 1'b1;
        adv(2);
        chk("R7 re-enable with low level requests", start_req, 1'b1);
        adv(1);

        // R8, R9, R10: sweep of bus-cycle qualifiers after a clean cycle
        for (int m = 0; m < 8; m++) begin
            dma_cyc = 1'b0; last_xfer = 1'b0; rfsh_cyc = 1'b0;
            adv(1);
            dma_cyc = m[0]; last_xfer = m[1]; rfsh_cyc = m[2];
            #0.5;
            chk($sformatf("R8 R9 R10 strobe sweep %0d", m), tend_n, !(m[0] && m[1]));
        end
        dma_cyc = 1'b0; last_xfer = 1'b0; rfsh_cyc = 1'b0;
        adv(1);

        // R8: disabled channel keeps the strobe high
        chan_en = 1'b0; dma_cyc = 1'b1; last_xfer = 1'b1;
        #0.5;
        chk("R8 strobe high when disabled", tend_n, 1'b1);
        chan_en = 1'b1;
        #0.5;
        chk("R8 strobe low on final DMA cycle", tend_n, 1'b0);

        // R9: foreign cycle between final read and write
        adv(1);
        dma_cyc = 1'b0; #0.5;
        chk("R9 foreign cycle keeps strobe high", tend_n, 1'b1);
        adv(1);
        dma_cyc = 1'b1; #0.5;
        chk("R8 strobe low on final write", tend_n, 1'b0);

        // R10: refresh directly after the final cycle may hold the strobe low
        adv(1);
        dma_cyc = 1'b0; last_xfer = 1'b0; rfsh_cyc = 1'b1; #0.5;
        chk("R10 refresh after final is defined", (tend_n === 1'b0) || (tend_n === 1'b1), 1'b1);
        adv(1);
        chk("R10 second refresh cycle is defined", (tend_n === 1'b0) || (tend_n === 1'b1), 1'b1);
        rfsh_cyc = 1'b0; #0.5;
        chk("R9 strobe high after refresh run", tend_n, 1'b1);

        // R10: refresh after a non-final DMA cycle keeps the strobe high
        adv(1);
        dma_cyc = 1'b1; last_xfer = 1'b0; #0.5;
        chk("R8 non-final DMA cycle high", tend_n, 1'b1);
        adv(1);
        dma_cyc = 1'b0; rfsh_cyc = 1'b1; #0.5;
        chk("R10 refresh after non-final high", tend_n, 1'b1);
        rfsh_cyc = 1'b0;
        adv(2);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule